// File: doc/BRIEF.md
# GPIO Pin Configuration Register File

This block holds the per-pin setup of an eight-pin general-purpose I/O port. The setup covers alternate-function routing, three drive-strength selects, open-drain, pull-up, pull-down, slew limiting, digital enable and analog selection. Each stored value appears directly on an output so the pad ring and the pin multiplexer can use it. A small word-addressed bus reads and writes the registers. Read data and the error strobe are registered and appear one cycle after the request.

Changes to the alternate-function select are guarded in two stages. A two-state lock machine starts in `ST_LOCKED`. It moves to `ST_OPEN` on the `KEY_MATCH` transition, which is a write of the unlock key to the lock word. The `KEY_MISS` transition is a write of any other value to the lock word, and it returns the machine to `ST_LOCKED`. A commit mask can only be rewritten in `ST_OPEN`, and a write to the alternate-function select changes only the bits the mask allows.

The parameter `EXTENDED` chooses between a reduced map and an extended map. The reduced map holds only the alternate-function select and the identification bytes. The extended map adds all other configuration registers, the lock word and the commit mask. The two maps return different identification bytes. Unmapped and reserved words read as zero, ignore writes and pulse an error strobe.

Top module: `gpcfg_regs`

## Requirements
- R1: After reset:
  - the lock word reads 1 and the commit mask reads 0xFF;
  - the 2 mA drive register reads 0xFF;
  - the alternate-function select and every other configuration register read 0.
  The outputs carry the same values.
- R2: In the extended map:
  - a write of 0x0ACCE551 to byte offset 0x520 (word 0x148) takes the lock machine to `ST_OPEN`, and the lock word then reads 0;
  - a write of any other value there takes the machine to `ST_LOCKED`, and the lock word then reads 1.
- R3: The commit mask at byte offset 0x524 takes a write only in `ST_OPEN`, and it keeps the low 8 bits of that write.
- R4: A write to the alternate-function select at byte offset 0x420 replaces only the bit positions where the commit mask is 1. Every other bit keeps its old value.
- R5: In the extended map, each of these registers keeps the low 8 bits written and drives them on its own output. No register disturbs another. The byte offsets are:
  - 0x500: 2 mA drive
  - 0x504: 4 mA drive
  - 0x508: 8 mA drive
  - 0x50C: open drain
  - 0x510: pull-up
  - 0x514: pull-down
  - 0x518: slew
  - 0x51C: digital enable
  - 0x528: analog select
- R6: Byte offsets 0xFD0 to 0xFFC return one identification byte per word, with index (offset-0xFD0)/4. The byte lists are:
  - extended map: 00 00 00 00 61 00 18 01 0D F0 05 B1
  - reduced map: 00 00 00 00 61 10 04 00 0D F0 05 B1
- R7: The following words read as 0 and ignore writes:
  - every word below byte offset 0x420;
  - the reserved window from the reserved start up to 0xFCC, where the reserved start is 0x52C in the extended map and 0x424 in the reduced map;
  - the identification words, for writes only.
- R8: `bus_err` is 1 for exactly one cycle after each access that R7 rejects. It stays 0 after an accepted access.
- R9: The accepting clock edge applies a write. The same edge loads a read result into `bus_rdata`, which holds it until the next read.
- R10: In the reduced map, the words at 0x500 to 0x528 are reserved, including the lock word and the commit mask. The lock therefore stays closed, the commit mask stays 0xFF, and the alternate-function select can be written in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle strobe for a rejected access |
| cfg_altfn | output | PINS | Alternate-function select |
| cfg_commit | output | PINS | Commit mask |
| cfg_drive2 | output | PINS | 2 mA drive select |
| cfg_drive4 | output | PINS | 4 mA drive select |
| cfg_drive8 | output | PINS | 8 mA drive select |
| cfg_opendrain | output | PINS | Open-drain enable |
| cfg_pullup | output | PINS | Pull-up enable |
| cfg_pulldown | output | PINS | Pull-down enable |
| cfg_slew | output | PINS | Slew-limit enable |
| cfg_digen | output | PINS | Digital enable |
| cfg_analog | output | PINS | Analog select |

## Verification
The guarded write is first tried with the commit mask at 0xFF and then at 0x0F, using complementary data patterns. Only the mask can account for the difference between the two results. Commit writes are tried in both lock states, and the lock is also fed a key with one wrong high bit, which separates a full 32-bit key compare from a truncated one. Each plain register gets a distinct byte with junk in its upper bits, and all of them are read back afterwards. This exposes any swapped offset, lost write or crosstalk. Reserved, low and identification words are probed in both maps, and a snapshot of every output is taken afterwards. This shows whether a rejected write leaked into any register.

// File: rtl/gpcfg_pkg.sv
package gpcfg_pkg;

    typedef enum logic [2:0] {
        RG_BAD, RG_ALTFN, RG_PLAIN, RG_LOCK, RG_COMMIT, RG_IDENT
    } region_e;

    typedef enum logic {ST_LOCKED, ST_OPEN} lock_state_e;

    localparam int ADDR_W  = 10;
    localparam int N_PLAIN = 9;

    // plain slots 0..7 sit at consecutive words from 0x140, slot 8 at 0x14A
    function automatic logic [ADDR_W-1:0] plain_waddr(input int slot);
        return (slot == N_PLAIN - 1) ? 10'h14A : 10'h140 + 10'(slot);
    endfunction

    function automatic logic [7:0] ident_byte(input logic ext, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd4:    b = 8'h61;
            4'd5:    b = ext ? 8'h00 : 8'h10;
            4'd6:    b = ext ? 8'h18 : 8'h04;
            4'd7:    b = ext ? 8'h01 : 8'h00;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpcfg_decode.sv
module gpcfg_decode
    import gpcfg_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic [ADDR_W-1:0]  waddr,
    output region_e            region,
    output logic [N_PLAIN-1:0] plain_hit,
    output logic [3:0]         ident_idx
);
    localparam logic [ADDR_W-1:0] W_ALTFN  = 10'h108;
    localparam logic [ADDR_W-1:0] W_LOCK   = 10'h148;
    localparam logic [ADDR_W-1:0] W_COMMIT = 10'h149;
    localparam logic [ADDR_W-1:0] W_RSVD   = EXTENDED ? 10'h14B : 10'h109;
    localparam logic [ADDR_W-1:0] W_IDENT  = 10'h3F4;

    for (genvar i = 0; i < N_PLAIN; i++) begin : g_hit
        if (plain_waddr(i) < W_RSVD) begin : g_live
            assign plain_hit[i] = (waddr == plain_waddr(i));
        end else begin : g_dead
            assign plain_hit[i] = 1'b0;
        end
    end

    always_comb begin
        region = RG_BAD;
        if (|plain_hit)                                 region = RG_PLAIN;
        else if (waddr == W_ALTFN)                      region = RG_ALTFN;
        else if (waddr == W_LOCK   && W_LOCK   < W_RSVD) region = RG_LOCK;
        else if (waddr == W_COMMIT && W_COMMIT < W_RSVD) region = RG_COMMIT;
        else if (waddr >= W_IDENT)                      region = RG_IDENT;
    end

    assign ident_idx = 4'(waddr - W_IDENT);

endmodule

// File: rtl/gpcfg_lock_fsm.sv
module gpcfg_lock_fsm
    import gpcfg_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = 32'h0ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              is_locked
);
    localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (lock_wr && wdata == KEY_W) state_d = ST_OPEN;   // KEY_MATCH
            ST_OPEN:   if (lock_wr && wdata != KEY_W) state_d = ST_LOCKED; // KEY_MISS
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_LOCKED: is_locked = 1'b1;
            ST_OPEN:   is_locked = 1'b0;
        endcase
    end

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) == ST_LOCKED) |-> $past(lock_wr && wdata == KEY_W)); // R2
    AST_MISS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata != KEY_W) |=> (state_q == ST_LOCKED)); // R2

endmodule

// File: rtl/gpcfg_plain_bank.sv
module gpcfg_plain_bank
    import gpcfg_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [N_PLAIN-1:0]            plain_hit,
    input  logic [PINS-1:0]               wdata,
    output logic [N_PLAIN-1:0][PINS-1:0]  q
);
    for (genvar i = 0; i < N_PLAIN; i++) begin : g_reg
        localparam logic [PINS-1:0] RST_VAL = (i == 0) ? '1 : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     q[i] <= RST_VAL;
            else if (wr_en && plain_hit[i]) q[i] <= wdata;
        end
    end

    AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R5

endmodule

// File: rtl/gpcfg_regs.sv
module gpcfg_regs
    import gpcfg_pkg::*;
#(
    parameter bit          EXTENDED   = 1'b1,
    parameter int          PINS       = 8,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] UNLOCK_KEY = 32'h0ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [9:0]        bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [PINS-1:0]   cfg_altfn,
    output logic [PINS-1:0]   cfg_commit,
    output logic [PINS-1:0]   cfg_drive2,
    output logic [PINS-1:0]   cfg_drive4,
    output logic [PINS-1:0]   cfg_drive8,
    output logic [PINS-1:0]   cfg_opendrain,
    output logic [PINS-1:0]   cfg_pullup,
    output logic [PINS-1:0]   cfg_pulldown,
    output logic [PINS-1:0]   cfg_slew,
    output logic [PINS-1:0]   cfg_digen,
    output logic [PINS-1:0]   cfg_analog
);
    region_e                      region;
    logic [N_PLAIN-1:0]           plain_hit;
    logic [3:0]                   ident_idx;
    logic [N_PLAIN-1:0][PINS-1:0] plain_q;
    logic [PINS-1:0]              altfn_q, commit_q, plain_rd;
    logic [DATA_W-1:0]            rd_mux;
    logic                         is_locked, wr_en, rd_en, reject;

    assign wr_en = bus_valid &&  bus_write;
    assign rd_en = bus_valid && !bus_write;

    gpcfg_decode #(.EXTENDED(EXTENDED)) u_decode (
        .waddr(bus_waddr), .region(region), .plain_hit(plain_hit), .ident_idx(ident_idx)
    );

    gpcfg_lock_fsm #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
        .clk(clk), .rst_n(rst_n), .lock_wr(wr_en && region == RG_LOCK),
        .wdata(bus_wdata), .is_locked(is_locked)
    );

    gpcfg_plain_bank #(.PINS(PINS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .plain_hit(plain_hit),
        .wdata(bus_wdata[PINS-1:0]), .q(plain_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            altfn_q  <= '0;
            commit_q <= '1;
        end else begin
            if (wr_en && region == RG_ALTFN)
                altfn_q <= (altfn_q & ~commit_q) | (bus_wdata[PINS-1:0] & commit_q);
            if (wr_en && region == RG_COMMIT && !is_locked)
                commit_q <= bus_wdata[PINS-1:0];
        end
    end

    always_comb begin
        plain_rd = '0;
        for (int i = 0; i < N_PLAIN; i++)
            if (plain_hit[i]) plain_rd = plain_rd | plain_q[i];
    end

    always_comb begin
        unique case (region)
            RG_ALTFN:  rd_mux = DATA_W'(altfn_q);
            RG_PLAIN:  rd_mux = DATA_W'(plain_rd);
            RG_LOCK:   rd_mux = DATA_W'(is_locked);
            RG_COMMIT: rd_mux = DATA_W'(commit_q);
            RG_IDENT:  rd_mux = DATA_W'(ident_byte(EXTENDED, ident_idx));
            default:   rd_mux = '0;
        endcase
    end

    assign reject = bus_valid && (region == RG_BAD || (bus_write && region == RG_IDENT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (rd_en) bus_rdata <= rd_mux;
            bus_err <= reject;
        end
    end

    assign cfg_altfn     = altfn_q;
    assign cfg_commit    = commit_q;
    assign cfg_drive2    = plain_q[0];
    assign cfg_drive4    = plain_q[1];
    assign cfg_drive8    = plain_q[2];
    assign cfg_opendrain = plain_q[3];
    assign cfg_pullup    = plain_q[4];
    assign cfg_pulldown  = plain_q[5];
    assign cfg_slew      = plain_q[6];
    assign cfg_digen     = plain_q[7];
    assign cfg_analog    = plain_q[8];

    AST_COMMIT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_q != $past(commit_q)) |-> !$past(is_locked)); // R3
    AST_ALTFN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((altfn_q ^ $past(altfn_q)) & ~$past(commit_q)) == '0); // R4
    AST_ERR_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid)); // R8
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(region) == RG_BAD) |-> (bus_rdata == '0)); // R7

endmodule

// File: tb/tb_gpcfg_regs.sv
`timescale 1ns/1ps
module tb_gpcfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [9:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_x, rdata_b;
    logic        err_x, err_b;
    logic [7:0]  x_cfg [11];
    logic [7:0]  b_cfg [11];
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    gpcfg_regs #(.EXTENDED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(rdata_x), .bus_err(err_x),
        .cfg_altfn(x_cfg[0]), .cfg_commit(x_cfg[1]), .cfg_drive2(x_cfg[2]), .cfg_drive4(x_cfg[3]),
        .cfg_drive8(x_cfg[4]), .cfg_opendrain(x_cfg[5]), .cfg_pullup(x_cfg[6]),
        .cfg_pulldown(x_cfg[7]), .cfg_slew(x_cfg[8]), .cfg_digen(x_cfg[9]), .cfg_analog(x_cfg[10])
    );

    gpcfg_regs #(.EXTENDED(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .bus_err(err_b),
        .cfg_altfn(b_cfg[0]), .cfg_commit(b_cfg[1]), .cfg_drive2(b_cfg[2]), .cfg_drive4(b_cfg[3]),
        .cfg_drive8(b_cfg[4]), .cfg_opendrain(b_cfg[5]), .cfg_pullup(b_cfg[6]),
        .cfg_pulldown(b_cfg[7]), .cfg_slew(b_cfg[8]), .cfg_digen(b_cfg[9]), .cfg_analog(b_cfg[10])
    );

    localparam int PLAIN_OFS [9] = '{'h500, 'h504, 'h508, 'h50C, 'h510, 'h514, 'h518, 'h51C, 'h528};
    localparam logic [7:0] ID_X [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    localparam logic [7:0] ID_B [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one access; results visible at the negedge after the accepting edge (R9)
    task automatic access(input logic wr, input int ofs, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_waddr = 10'(ofs >> 2); bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 ext altfn port", 32'(x_cfg[0]), 32'h00);
        check("R1 ext commit port", 32'(x_cfg[1]), 32'hFF);
        check("R1 ext drive2 port", 32'(x_cfg[2]), 32'hFF);
        check("R1 basic drive2 port", 32'(b_cfg[2]), 32'hFF);
        access(1'b0, 'h520, 0); check("R1 ext lock reads 1", rdata_x, 32'h1);
        access(1'b0, 'h524, 0); check("R1 ext commit reads FF", rdata_x, 32'hFF);
        access(1'b0, 'h500, 0); check("R1 ext drive2 reads FF", rdata_x, 32'hFF);
        access(1'b0, 'h504, 0); check("R1 ext drive4 reads 0", rdata_x, 32'h0);
        access(1'b0, 'h420, 0); check("R1 altfn reads 0", rdata_x, 32'h0);
        for (int i = 3; i < 11; i++) check("R1 ext plain port zero", 32'(x_cfg[i]), 32'h0);
    endtask

    task automatic t_lock_commit;
        access(1'b1, 'h524, 32'h0F);
        check("R3 commit ignored while locked", 32'(x_cfg[1]), 32'hFF);
        access(1'b1, 'h520, 32'h0ACCE551);
        access(1'b0, 'h520, 0); check("R2 key unlocks", rdata_x, 32'h0);
        check("R9 rdata holds after write", rdata_x, 32'h0);
        access(1'b1, 'h524, 32'hABCD_120F);
        access(1'b0, 'h524, 0); check("R3 commit written when open", rdata_x, 32'h0F);
        access(1'b1, 'h520, 32'h1ACCE551);
        access(1'b0, 'h520, 0); check("R2 wrong key locks", rdata_x, 32'h1);
        access(1'b1, 'h524, 32'h33);
        check("R3 commit held after relock", 32'(x_cfg[1]), 32'h0F);
    endtask

    task automatic t_altfn_full;
        access(1'b1, 'h420, 32'h5A);
        check("R4 ext altfn full mask", 32'(x_cfg[0]), 32'h5A);
        check("R10 basic altfn full mask", 32'(b_cfg[0]), 32'h5A);
    endtask

    task automatic t_altfn_mask;
        access(1'b1, 'h420, 32'hFFFF_FFA5);
        check("R4 altfn only committed bits", 32'(x_cfg[0]), 32'h55);
        access(1'b0, 'h420, 0); check("R4 altfn readback", rdata_x, 32'h55);
        check("R10 basic altfn unmasked", rdata_b, 32'hA5);
    endtask

    task automatic t_plain;
        for (int i = 0; i < 9; i++) begin
            access(1'b1, PLAIN_OFS[i], 32'hDEAD_BE00 | 32'((8'h11 * (i + 1)) ^ 8'h0C));
            check("R5 write accepted no err", 32'(err_x), 32'h0);
            check("R10 basic plain write err", 32'(err_b), 32'h1);
        end
        for (int i = 0; i < 9; i++) begin
            logic [7:0] pat = 8'((8'h11 * (i + 1)) ^ 8'h0C);
            access(1'b0, PLAIN_OFS[i], 0);
            check("R5 plain readback", rdata_x, 32'(pat));
            check("R5 plain port", 32'(x_cfg[(i == 8) ? 10 : i + 2]), 32'(pat));
            check("R10 basic plain reads 0", rdata_b, 32'h0);
        end
        check("R10 basic drive2 port kept", 32'(b_cfg[2]), 32'hFF);
    endtask

    task automatic t_ident;
        for (int k = 0; k < 12; k++) begin
            access(1'b0, 'hFD0 + 4 * k, 0);
            check("R6 ext ident byte", rdata_x, 32'(ID_X[k]));
            check("R6 basic ident byte", rdata_b, 32'(ID_B[k]));
            check("R8 ident read no err", 32'(err_x | err_b), 32'h0);
        end
    endtask

    task automatic t_reserved;
        logic [7:0] snap [11];
        int ofs_list [6] = '{'h000, 'h41C, 'h424, 'h4FC, 'h52C, 'hFCC};
        for (int i = 0; i < 11; i++) snap[i] = x_cfg[i];
        for (int k = 0; k < 6; k++) begin
            access(1'b0, ofs_list[k], 0);
            check("R7 reserved reads 0", rdata_x, 32'h0);
            check("R8 reserved read err", 32'(err_x), 32'h1);
            @(negedge clk);
            check("R8 err lasts one cycle", 32'(err_x), 32'h0);
        end
        access(1'b1, 'h000, 32'hFF); access(1'b1, 'h52C, 32'hFF);
        access(1'b1, 'h4FC, 32'hFF);
        access(1'b1, 'hFD4, 32'hFF);
        check("R8 ident write err", 32'(err_x), 32'h1);
        access(1'b0, 'hFD4, 0); check("R7 ident unchanged", rdata_x, 32'h0);
        for (int i = 0; i < 11; i++) check("R7 rejected writes leave config", 32'(x_cfg[i]), 32'(snap[i]));
        access(1'b1, 'h520, 32'h0ACCE551);
        check("R10 basic lock write err", 32'(err_b), 32'h1);
        access(1'b1, 'h524, 32'h00);
        check("R10 basic commit stays FF", 32'(b_cfg[1]), 32'hFF);
        access(1'b0, 'h424, 0);
        check("R10 basic 0x424 err", 32'(err_b), 32'h1);
        check("R7 basic 0x424 reads 0", rdata_b, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_altfn_full();
        t_lock_commit();
        t_altfn_mask();
        t_plain();
        t_ident();
        t_reserved();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule